// File: doc/BRIEF.md
# ADC Window Compare Detector

This block watches the stream of results coming out of a 10-bit converter and raises a sticky flag when a result lands where the controller has asked to be told about. It takes two programmable 16-bit limits, each written as a high byte and a low byte. One is a "greater-than" limit and the other is a "less-than" limit. On every conversion-complete strobe it compares the new result with both limits.

The relative order of the two limits selects the meaning of the window. If the less-than limit is above the greater-than limit, the window is the band between them. Otherwise the window is everything outside the band. One pair of registers therefore covers both uses.

Between flagged events the converter can run in the background without disturbing the controller. A qualifying result sets the flag. The flag stays set until software clears it. An interrupt request is raised while the flag is set and the enable is on.

The result can be placed in the 16-bit data word right-justified or left-justified. The limits are written in the same layout, and every comparison is unsigned on the full 16-bit word.

Top module: `adc_window_cmp`

## Requirements
- R1: After reset, win_flag_o and win_irq_o are both 0.
- R2: The compared word is {6'b0, result_i} when left_align_i is 0 and {result_i, 6'b0} when left_align_i is 1. Each limit is {hi byte, lo byte}. All comparisons are unsigned on 16 bits.
- R3: When the less-than limit is strictly greater than the greater-than limit (inside mode), a strobed result sets the flag only if word > GT and word < LT.
- R4: When the less-than limit is less than or equal to the greater-than limit (outside mode), a strobed result sets the flag if word > GT or word < LT.
- R5: The comparison happens only in a cycle with done_i high, using the limits present in that cycle. Limit or result changes without the strobe do not change the flag.
- R6: The flag is sticky. flag_clr_i clears it one cycle later. If a hit and a clear fall in the same cycle, the flag ends up set.
- R7: win_irq_o is high exactly when the flag is set and int_en_i is high. A strobed result that misses the window leaves the flag unchanged.
- R8: A word equal to either limit does not count as beyond that limit (both comparisons are strict).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | Conversion-complete strobe |
| result_i | input | 10 | Newly latched conversion result |
| left_align_i | input | 1 | 1 = result in word bits 15:6, 0 = bits 9:0 |
| gt_hi_i | input | 8 | Greater-than limit, high byte |
| gt_lo_i | input | 8 | Greater-than limit, low byte |
| lt_hi_i | input | 8 | Less-than limit, high byte |
| lt_lo_i | input | 8 | Less-than limit, low byte |
| int_en_i | input | 1 | Window interrupt enable |
| flag_clr_i | input | 1 | Software clear of the window flag |
| win_flag_o | output | 1 | Sticky window-condition flag |
| win_irq_o | output | 1 | Window interrupt request |

## Verification
Random results and limits exercise both window modes and both result alignments. Inside-mode draws show whether the hit test uses AND. Outside-mode draws show whether it uses OR. Directed cases put the result exactly on each limit, and set the two limits equal, to distinguish strict from inclusive comparisons and to check which mode the tie selects. Other cases change the limits without a strobe, and raise a hit together with a clear, to confirm that only strobe cycles are evaluated and that setting the flag wins over clearing it.

// File: rtl/adc_window_cmp.sv
`timescale 1ns/1ps
module adc_window_cmp #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              left_align_i,
  input  logic [BYTE_W-1:0] gt_hi_i,
  input  logic [BYTE_W-1:0] gt_lo_i,
  input  logic [BYTE_W-1:0] lt_hi_i,
  input  logic [BYTE_W-1:0] lt_lo_i,
  input  logic              int_en_i,
  input  logic              flag_clr_i,
  output logic              win_flag_o,
  output logic              win_irq_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word, gt_lim, lt_lim;
  logic above, below, inside_mode, hit;

  assign word        = left_align_i ? {result_i, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, result_i};
  assign gt_lim      = {gt_hi_i, gt_lo_i};
  assign lt_lim      = {lt_hi_i, lt_lo_i};
  assign above       = word > gt_lim;
  assign below       = word < lt_lim;
  assign inside_mode = lt_lim > gt_lim;
  assign hit         = inside_mode ? (above & below) : (above | below);

  always_ff @(posedge clk) begin
    if (!rst_n)              win_flag_o <= 1'b0;
    else if (done_i && hit)  win_flag_o <= 1'b1;
    else if (flag_clr_i)     win_flag_o <= 1'b0;
  end

  assign win_irq_o = win_flag_o & int_en_i;

  // R5 / R7: no strobe and no clear leaves the flag alone
  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !flag_clr_i) |=> $stable(win_flag_o));
  // R6: a clear with no strobe empties the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !done_i) |=> !win_flag_o);
  // R3 / R4: a qualifying strobe always leaves the flag set
  a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && hit) |=> win_flag_o);
  // R7: a missing strobe does not raise a clear flag
  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !hit && !win_flag_o) |=> !win_flag_o);
  // R7: request only with flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    win_irq_o |-> (win_flag_o && int_en_i));
endmodule

// File: tb/sim_adc_window_cmp.sv
`timescale 1ns/1ps
module sim_adc_window_cmp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic done_i = 0, left_align_i = 0, int_en_i = 0, flag_clr_i = 0;
  logic [9:0] result_i = '0;
  logic [7:0] gt_hi_i = 0, gt_lo_i = 0, lt_hi_i = 0, lt_lo_i = 0;
  logic win_flag_o, win_irq_o;
  int checks = 0, errors = 0;
  bit model = 0;

  always #10 clk = ~clk;

  adc_window_cmp u0 (.*);

  function automatic bit exp_hit(input logic [9:0] r, input bit la,
                                 input logic [15:0] gt, input logic [15:0] lt);
    logic [15:0] w;
    w = la ? {r, 6'b0} : {6'b0, r};
    if (lt > gt) return (w > gt) && (w < lt);
    return (w > gt) || (w < lt);
  endfunction

  task automatic check(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // called just after a negedge; applies inputs, clocks, checks at next negedge
  task automatic step(input string req, input bit dn, input logic [9:0] r, input bit la,
                      input logic [15:0] gt, input logic [15:0] lt, input bit en, input bit clr);
    done_i = dn; result_i = r; left_align_i = la;
    {gt_hi_i, gt_lo_i} = gt; {lt_hi_i, lt_lo_i} = lt;
    int_en_i = en; flag_clr_i = clr;
    if (dn && exp_hit(r, la, gt, lt)) model = 1;
    else if (clr) model = 0;
    @(posedge clk); @(negedge clk);
    done_i = 0; flag_clr_i = 0;
    check(req, win_flag_o, model, "flag");
    check("R7", win_irq_o, model & en, "irq");
  endtask

  task automatic clear_flag();
    step("R6", 0, 0, 0, 16'h0, 16'h0, 0, 1);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    check("R1", win_flag_o, 0, "reset flag");
    check("R1", win_irq_o, 0, "reset irq");
    rst_n = 1;
    @(negedge clk);

    // R3 inside: GT=100, LT=200
    step("R3", 1, 10'd150, 0, 16'd100, 16'd200, 1, 0);
    clear_flag();
    step("R3", 1, 10'd250, 0, 16'd100, 16'd200, 1, 0);
    step("R3", 1, 10'd50,  0, 16'd100, 16'd200, 1, 0);
    // R8 boundaries inside
    step("R8", 1, 10'd100, 0, 16'd100, 16'd200, 1, 0);
    step("R8", 1, 10'd200, 0, 16'd100, 16'd200, 1, 0);
    // R4 outside: GT=200, LT=100
    step("R4", 1, 10'd150, 0, 16'd200, 16'd100, 1, 0);
    step("R8", 1, 10'd200, 0, 16'd200, 16'd100, 1, 0);
    step("R8", 1, 10'd100, 0, 16'd200, 16'd100, 1, 0);
    step("R4", 1, 10'd201, 0, 16'd200, 16'd100, 1, 0);
    clear_flag();
    step("R4", 1, 10'd99, 0, 16'd200, 16'd100, 0, 0);
    clear_flag();
    // R4 tie: LT==GT -> outside, only equal value misses
    step("R4", 1, 10'd300, 0, 16'd300, 16'd300, 1, 0);
    step("R4", 1, 10'd301, 0, 16'd300, 16'd300, 1, 0);
    clear_flag();
    // R2 left alignment: 10'd2 -> 16'h0080
    step("R2", 1, 10'd2, 1, 16'h0070, 16'h0090, 1, 0);
    clear_flag();
    step("R2", 1, 10'd2, 0, 16'h0070, 16'h0090, 1, 0);
    // R5 no strobe: would-hit values do nothing
    step("R5", 0, 10'd150, 0, 16'd100, 16'd200, 1, 0);
    step("R5", 0, 10'd5, 0, 16'd200, 16'd100, 1, 0);
    // R6 hit and clear together -> set
    step("R6", 1, 10'd150, 0, 16'd100, 16'd200, 1, 1);
    step("R6", 0, 10'd0, 0, 16'd100, 16'd200, 1, 0);
    // R7 enable gating while set
    step("R7", 0, 10'd0, 0, 16'd100, 16'd200, 0, 0);
    // R7 miss leaves set flag set
    step("R7", 1, 10'd50, 0, 16'd100, 16'd200, 1, 0);
    clear_flag();

    for (int i = 0; i < 400; i++) begin
      logic [9:0]  r;
      logic [15:0] gt, lt;
      bit la, dn, en, clr;
      r = 10'($urandom); la = 1'($urandom);
      if (la) begin
        gt = 16'($urandom); lt = 16'($urandom);
      end else begin
        gt = 16'($urandom % 1024); lt = 16'($urandom % 1024);
      end
      dn = ($urandom % 4) != 0; en = 1'($urandom); clr = ($urandom % 3) == 0;
      step((lt > gt) ? "R3" : "R4", dn, r, la, gt, lt, en, clr);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule